// File: doc/BRIEF.md
# Indirect Memory Access Bridge

This block lets a host that can only issue byte-wide I/O register accesses reach a full 32-bit memory space on an internal core bus. The host sees a window of five byte registers: four of them together hold the target address, and the fifth is a data port. Reading or writing the data port launches exactly one single-byte memory cycle on the core bus at the address held in the four address bytes.

The host port is a simplified I/O register interface. It carries an offset, a one-cycle strobe, a direction bit and byte data. Back to the host it returns a 2-bit wait status that plays the part of a bus sync field, together with read data. Address-register accesses finish at once with a short-wait indication. A data-port access holds the host in long-wait until the core bus acknowledges the transfer, and then reports ready.

The core side is a request/acknowledge memory master. The request stays up, with a stable command, until the acknowledge arrives.

Top module: `idx_mem_bridge`

## Requirements
- R1: Offsets 0 to 3 select the address bytes, offset i holding address bits 8i+7..8i. A strobed write loads the byte, and a strobed read returns it. In the cycle after either strobe, io_sync is 2'b01 (short-wait, complete), and for a read io_rdata holds the byte.
- R2: A strobed write to offset 4 raises mem_req in the next cycle with mem_we=1, mem_addr equal to the four address bytes and mem_wdata equal to the written byte.
- R3: A strobed read from offset 4 raises mem_req in the next cycle with mem_we=0. The mem_rdata value present in the acknowledge cycle appears on io_rdata in the following cycle.
- R4: While mem_req is high, io_sync is 2'b10 (long-wait). In the cycle after the acknowledge, io_sync is 2'b11 (ready after long-wait) and mem_req is low.
- R5: mem_req, mem_addr, mem_we and mem_wdata hold their values until mem_ack is seen with mem_req high.
- R6: Offsets 5 to 7 start no core-bus cycle and complete with io_sync 2'b01. A read from them returns 8'hFF, and a write to them changes nothing.
- R7: A strobe that arrives while a core-bus transfer is outstanding is ignored. It changes no register and produces no response.
- R8: The address bytes keep their values after a data-port access and do not increment.
- R9: A synchronous active-high reset clears the address bytes and io_rdata to zero, drops mem_req and sets io_sync to 2'b00. This applies even in the middle of a transfer.
- R10: In an idle cycle with no strobe, io_sync is 2'b00 in the next cycle.
- R11: io_rdata changes only on read completions (R1, R3 and R6 reads). Write completions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_stb | input | 1 | One-cycle host access strobe |
| io_wr | input | 1 | 1 = host write, 0 = host read |
| io_off | input | 3 | Register offset in the window |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte |
| io_sync | output | 2 | 00 none, 01 short-wait done, 10 long-wait, 11 ready after long-wait |
| mem_req | output | 1 | Core-bus request, held until acknowledged |
| mem_we | output | 1 | Core-bus write enable |
| mem_addr | output | 32 | Core-bus byte address |
| mem_wdata | output | 8 | Core-bus write byte |
| mem_rdata | input | 8 | Core-bus read byte |
| mem_ack | input | 1 | Core-bus acknowledge |

## Verification
A wrong busy state shows up within one cycle as a mismatch between mem_req and the long-wait code on io_sync. If the bridge wrongly accepts a strobe while busy, a short-wait response or a changed address byte appears, and that byte can be read back on the next idle access. A corrupt address or direction register shows on mem_addr or mem_we in the first request cycle. A missed read capture shows on io_rdata in the cycle right after the acknowledge. The reference model compares every output on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/idxb_pkg.sv
package idxb_pkg;

  typedef enum logic [1:0] {
    SYNC_NONE  = 2'b00,
    SYNC_SHORT = 2'b01,
    SYNC_LONG  = 2'b10,
    SYNC_READY = 2'b11
  } sync_e;

  typedef enum logic [1:0] {
    ACC_ADDR  = 2'd0,
    ACC_DATA  = 2'd1,
    ACC_OTHER = 2'd2
  } acc_e;

  // Window layout: address bytes first, the data port right after them.
  function automatic acc_e classify(input int unsigned off, input int unsigned nbytes);
    if (off < nbytes)       return ACC_ADDR;
    else if (off == nbytes) return ACC_DATA;
    else                    return ACC_OTHER;
  endfunction

endpackage

// File: rtl/idxb_decode.sv
module idxb_decode
  import idxb_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int OFF_W      = 3
) (
  input  logic                  stb,
  input  logic                  wr,
  input  logic [OFF_W-1:0]      off,
  input  logic                  busy,
  output logic [ADDR_BYTES-1:0] addr_wr,
  output logic                  addr_rd,
  output logic                  other_rd,
  output logic                  start,
  output logic                  short_done
);

  logic accept;
  acc_e kind;

  always_comb begin
    accept = stb & ~busy;
    kind   = classify(int'(off), ADDR_BYTES);
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_wr
    assign addr_wr[i] = accept & wr & (off == OFF_W'(i));
  end

  always_comb begin
    addr_rd    = accept & ~wr & (kind == ACC_ADDR);
    other_rd   = accept & ~wr & (kind == ACC_OTHER);
    start      = accept & (kind == ACC_DATA);
    short_done = accept & (kind != ACC_DATA);
  end

endmodule

// File: rtl/idxb_addr_file.sv
module idxb_addr_file #(
  parameter int ADDR_BYTES = 4,
  parameter int BYTE_W     = 8,
  parameter int OFF_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_BYTES-1:0]        wr_en,
  input  logic [BYTE_W-1:0]            wdata,
  input  logic [OFF_W-1:0]             sel,
  output logic [ADDR_BYTES*BYTE_W-1:0] addr,
  output logic [BYTE_W-1:0]            rd_byte
);

  logic [BYTE_W-1:0] bytes_q [ADDR_BYTES];

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)           bytes_q[i] <= '0;
      else if (wr_en[i]) bytes_q[i] <= wdata;
    end
    assign addr[i*BYTE_W +: BYTE_W] = bytes_q[i];
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (sel == OFF_W'(i)) rd_byte = bytes_q[i];
    end
  end

endmodule

// File: rtl/idxb_core_fsm.sv
module idxb_core_fsm #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ack,
  output logic              busy,
  output logic              we,
  output logic [BYTE_W-1:0] wdata_q,
  output logic              fin,
  output logic              fin_rd
);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;
  st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      we      <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_WAIT;
          we      <= wr;
          wdata_q <= wr ? wdata : wdata_q;
        end
        ST_WAIT: if (ack) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy   = (st_q == ST_WAIT);
    fin    = busy & ack;
    fin_rd = fin & ~we;
  end

endmodule

// File: rtl/idx_mem_bridge.sv
module idx_mem_bridge
  import idxb_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int BYTE_W     = 8,
  parameter int OFF_W      = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         io_stb,
  input  logic                         io_wr,
  input  logic [OFF_W-1:0]             io_off,
  input  logic [BYTE_W-1:0]            io_wdata,
  output logic [BYTE_W-1:0]            io_rdata,
  output logic [1:0]                   io_sync,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_BYTES*BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0]            mem_wdata,
  input  logic [BYTE_W-1:0]            mem_rdata,
  input  logic                         mem_ack
);

  localparam int ADDR_W = ADDR_BYTES * BYTE_W;

  // Named internal events, also used by the bound checker.
  logic                  core_busy;
  logic                  ev_start;
  logic                  ev_short;
  logic                  ev_fin;
  logic                  ev_fin_rd;
  logic                  ev_addr_rd;
  logic                  ev_other_rd;
  logic [ADDR_BYTES-1:0] ev_addr_wr;
  logic [BYTE_W-1:0]     reg_byte;
  logic [ADDR_W-1:0]     addr_w;

  sync_e             sync_q;
  logic [BYTE_W-1:0] rdata_q;

  idxb_decode #(.ADDR_BYTES(ADDR_BYTES), .OFF_W(OFF_W)) u_dec (
    .stb        (io_stb),
    .wr         (io_wr),
    .off        (io_off),
    .busy       (core_busy),
    .addr_wr    (ev_addr_wr),
    .addr_rd    (ev_addr_rd),
    .other_rd   (ev_other_rd),
    .start      (ev_start),
    .short_done (ev_short)
  );

  idxb_addr_file #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .OFF_W(OFF_W)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ev_addr_wr),
    .wdata   (io_wdata),
    .sel     (io_off),
    .addr    (addr_w),
    .rd_byte (reg_byte)
  );

  idxb_core_fsm #(.BYTE_W(BYTE_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (ev_start),
    .wr      (io_wr),
    .wdata   (io_wdata),
    .ack     (mem_ack),
    .busy    (core_busy),
    .we      (mem_we),
    .wdata_q (mem_wdata),
    .fin     (ev_fin),
    .fin_rd  (ev_fin_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= SYNC_NONE;
      rdata_q <= '0;
    end else begin
      if (ev_fin)                      sync_q <= SYNC_READY;
      else if (core_busy || ev_start)  sync_q <= SYNC_LONG;
      else if (ev_short)               sync_q <= SYNC_SHORT;
      else                             sync_q <= SYNC_NONE;

      if (ev_fin_rd)        rdata_q <= mem_rdata;
      else if (ev_addr_rd)  rdata_q <= reg_byte;
      else if (ev_other_rd) rdata_q <= '1;
    end
  end

  always_comb begin
    io_sync  = sync_q;
    io_rdata = rdata_q;
    mem_req  = core_busy;
    mem_addr = addr_w;
  end

endmodule

// File: rtl/idxb_checker.sv
module idxb_checker #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_stb,
  input logic [1:0]        io_sync,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [BYTE_W-1:0] mem_wdata,
  input logic              ev_start
);

  AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (rst)
    ev_start |=> mem_req && io_sync == 2'b10); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req); // R5

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R5

  AST_LONG_WHILE_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> io_sync == 2'b10); // R4

  AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack |=> io_sync == 2'b11 && !mem_req); // R4

  AST_BUSY_STB_SILENT: assert property (@(posedge clk) disable iff (rst)
    io_stb && mem_req |=> io_sync != 2'b01); // R7

  AST_SHORT_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    io_sync == 2'b01 |-> !mem_req); // R6

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> io_sync == 2'b00 && !mem_req); // R9

endmodule

bind idx_mem_bridge idxb_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_stb    (io_stb),
  .io_sync   (io_sync),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .ev_start  (ev_start)
);

// File: tb/idx_mem_bridge_test.sv
module idx_mem_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_stb = 1'b0;
  logic        io_wr = 1'b0;
  logic [2:0]  io_off = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [1:0]  io_sync;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  idx_mem_bridge uut (
    .clk(clk), .rst(rst), .io_stb(io_stb), .io_wr(io_wr), .io_off(io_off),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_sync(io_sync),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int    vectors = 0;
  int    errors  = 0;
  int    cycles  = 0;
  bit    armed   = 1'b0;
  string tag     = "R9";

  // Behavioural reference model state.
  logic [7:0] m_byte [4];
  bit         m_busy;
  bit         m_we;
  logic [7:0] m_wdata;
  int         m_sync;
  logic [7:0] m_rdata;

  function automatic logic [31:0] model_addr();
    return {m_byte[3], m_byte[2], m_byte[1], m_byte[0]};
  endfunction

  function automatic logic [7:0] mem_fn(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[31:28]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    armed  <= 1'b1;
    if (rst) begin
      foreach (m_byte[i]) m_byte[i] = 8'h00;
      m_busy = 0; m_we = 0; m_wdata = 0; m_sync = 0; m_rdata = 0;
    end else if (m_busy) begin
      if (mem_ack) begin
        m_busy = 0;
        if (!m_we) m_rdata = mem_rdata;
        m_sync = 3;
      end else m_sync = 2;
    end else if (io_stb) begin
      if (io_off < 4) begin
        if (io_wr) m_byte[io_off] = io_wdata;
        else       m_rdata = m_byte[io_off];
        m_sync = 1;
      end else if (io_off == 4) begin
        m_busy = 1; m_we = io_wr;
        if (io_wr) m_wdata = io_wdata;
        m_sync = 2;
      end else begin
        if (!io_wr) m_rdata = 8'hFF;
        m_sync = 1;
      end
    end else m_sync = 0;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    if (armed) begin
      bit bad = 0;
      vectors++;
      if (io_sync !== 2'(m_sync)) begin
        bad = 1; $display("FAIL %s io_sync got %0d exp %0d", tag, io_sync, m_sync);
      end
      if (io_rdata !== m_rdata) begin
        bad = 1; $display("FAIL %s io_rdata got %h exp %h", tag, io_rdata, m_rdata);
      end
      if (mem_req !== m_busy) begin
        bad = 1; $display("FAIL %s mem_req got %b exp %b", tag, mem_req, m_busy);
      end
      if (m_busy) begin
        if (mem_addr !== model_addr()) begin
          bad = 1; $display("FAIL %s mem_addr got %h exp %h", tag, mem_addr, model_addr());
        end
        if (mem_we !== m_we) begin
          bad = 1; $display("FAIL %s mem_we got %b exp %b", tag, mem_we, m_we);
        end
        if (m_we && mem_wdata !== m_wdata) begin
          bad = 1; $display("FAIL %s mem_wdata got %h exp %h", tag, mem_wdata, m_wdata);
        end
      end
      if (bad) errors++;
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired (%s) got timeout exp completion", tag);
      finish_run();
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One host access; data-port accesses are acknowledged after 'delay' wait cycles.
  // 'inject' drives a stray write to offset 0 while the transfer is pending.
  task automatic access(input bit wr, input int off, input logic [7:0] d,
                        input int delay, input bit inject);
    @(negedge clk);
    io_stb = 1; io_wr = wr; io_off = 3'(off); io_wdata = d;
    @(negedge clk);
    io_stb = 0;
    if (off == 4) begin
      for (int k = 0; k <= delay; k++) begin
        if (inject && k == 0 && delay > 0) begin
          io_stb = 1; io_wr = 1; io_off = 3'd0; io_wdata = 8'hEE;
        end else io_stb = 0;
        mem_ack   = (k == delay);
        mem_rdata = (k == delay) ? mem_fn(mem_addr) : 8'h3C;
        @(negedge clk);
      end
      io_stb = 0; mem_ack = 0; mem_rdata = 8'h00;
    end
  endtask

  initial begin
    idle(3);
    rst = 0;
    tag = "R9";  access(0, 0, 0, 0, 0); access(0, 3, 0, 0, 0);
    tag = "R10"; idle(3);
    tag = "R1";
    access(1, 0, 8'h78, 0, 0); access(1, 1, 8'h56, 0, 0);
    access(1, 2, 8'h34, 0, 0); access(1, 3, 8'h12, 0, 0);
    for (int i = 0; i < 4; i++) access(0, i, 0, 0, 0);
    tag = "R11"; access(1, 2, 8'h34, 0, 0); idle(1);
    tag = "R2";  access(1, 4, 8'hA5, 0, 0); idle(1);
    access(1, 4, 8'h0F, 2, 0);
    tag = "R7";  access(1, 4, 8'h99, 3, 1);
    access(0, 0, 0, 0, 0);
    tag = "R3";  access(0, 4, 0, 2, 0); access(0, 4, 0, 0, 0);
    tag = "R8";  for (int i = 0; i < 4; i++) access(0, i, 0, 0, 0);
    tag = "R6";
    access(0, 5, 0, 0, 0); access(1, 6, 8'h11, 0, 0); access(0, 7, 0, 0, 0);
    access(1, 7, 8'h22, 0, 0); access(0, 1, 0, 0, 0);
    tag = "R5";
    access(1, 3, 8'hC0, 0, 0); access(1, 0, 8'hFE, 0, 0);
    access(0, 4, 0, 6, 1); access(1, 4, 8'h5B, 5, 0);
    tag = "R4";  access(0, 4, 0, 1, 0); access(0, 6, 0, 0, 0); access(0, 4, 0, 0, 0);
    tag = "R9";
    @(negedge clk); io_stb = 1; io_wr = 0; io_off = 3'd4;
    @(negedge clk); io_stb = 0;
    idle(2);
    rst = 1; @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) access(0, i, 0, 0, 0);
    idle(3);
    finish_run();
  end

endmodule